// File: doc/BRIEF.md
# Paged Memory Window Decoder

This block decodes cycles on a simple ISA-style bus for a battery-backed RAM of up to 2 MB. It owns a bank of eight byte-wide I/O registers at a fixed base address. Two of those registers control how the RAM is mapped into the memory space: a page register picks one of 64 pages of 32 KB, and a mode register turns on either a movable 32 KB paged window in the upper-memory area or one flat 2 MB linear range.

After reset no memory address is decoded; only the register bank answers, so the card cannot clash with other devices until software has mapped it. For every memory cycle that falls inside the active range, the block issues a registered RAM address, chip select, read and write strobes and the bus width taken from a configuration input. All outputs change one clock after the bus cycle is presented.

Top module: `nvram_window_dec`

## Requirements
- R1: Synchronous active-high reset clears the page and mode registers to 0x00 and drives every output to 0.
- R2: I/O cycles (bus_io=1) with an address in IO_BASE..IO_BASE+7 (default 0x140) are claimed: io_ack is 1 in the following cycle. Other addresses give io_ack=0. Locations other than offsets 4 and 5 read back 0x00, and writes to them change nothing.
- R3: Offset 4 holds the page register and offset 5 the mode register; each reads back the full 8-bit value last written. A read returns its data on bus_rdata one cycle after the cycle; bus_rdata is 0x00 otherwise.
- R4: While mode bits 7 and 6 are both 0, no memory cycle is decoded: ram_cs, ram_rd, ram_wr stay 0 and ram_addr is 0.
- R5: With mode bit 6 set and bit 7 clear, a memory cycle hits when its address lies in the 32 KB window starting at 0xA0000 + 0x8000 × mode[2:0] (so index 6 gives 0xD0000..0xD7FFF, index 7 the last window ending at 0xDFFFF).
- R6: In paged mode the RAM address is {page[5:0], bus_addr[14:0]}.
- R7: With mode bit 7 set, a memory cycle hits when bus_addr is in LIN_BASE..LIN_BASE+0x1FFFFF (default LIN_BASE 0x200000), and the RAM address is bus_addr − LIN_BASE.
- R8: When mode bits 7 and 6 are both set, linear mapping wins and the paged window is not decoded.
- R9: On a hit, ram_cs is 1 and ram_rd/ram_wr copy bus_rd/bus_wr one cycle later; a miss or an I/O cycle leaves all three at 0 and ram_addr at 0. A memory cycle never claims the register bank.
- R10: ram_wide equals the cfg_wide input (1 = 16-bit data, 0 = 8-bit) of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | Width strap: 1 = 16-bit, 0 = 8-bit |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 24 | Bus address |
| bus_wdata | input | 8 | Write data for register cycles |
| bus_rdata | output | 8 | Registered register read data |
| io_ack | output | 1 | Register bank claimed the previous cycle |
| ram_cs | output | 1 | RAM chip select |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 21 | RAM word address |
| ram_wide | output | 1 | Data width for the RAM cycle |

## Verification
The assertions watch, on every cycle, that reset leaves both control registers clear, that a write to a spare location disturbs neither control register, that a mode write is stored intact, that no chip select appears while both mapping bits are clear and that an I/O cycle never selects the RAM. Window placement for all eight indices, the page-to-address splice, the linear subtraction and its range edges, linear priority and the width strap are shown only by the bench, which replays random register programming and memory traffic against a model of the mapping.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 8;
  localparam int OFS_W     = $clog2(NUM_REGS);
  localparam int PAGE_OFS  = 4;
  localparam int MODE_OFS  = 5;
  localparam int LIN_BIT   = 7;
  localparam int PAG_BIT   = 6;
  localparam int IDX_W     = 3;

  typedef enum logic [1:0] {
    MAP_OFF    = 2'd0,
    MAP_PAGED  = 2'd1,
    MAP_LINEAR = 2'd2
  } map_mode_e;

  // linear mapping has priority over the paged window
  function automatic map_mode_e pick_mode(input logic lin_en, input logic pag_en);
    if (lin_en)      return MAP_LINEAR;
    else if (pag_en) return MAP_PAGED;
    else             return MAP_OFF;
  endfunction
endpackage

// File: rtl/nvw_regbank.sv
module nvw_regbank
  import nvw_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [PAGE_W-1:0] page_sel,
  output logic              lin_en,
  output logic              pag_en,
  output logic [IDX_W-1:0]  win_idx
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_loc
    if (i == PAGE_OFS || i == MODE_OFS) begin : g_store
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr_en && ofs == OFS_W'(i))
          q <= wdata;
      end
      assign regs[i] = q;
    end else begin : g_spare
      assign regs[i] = '0;
    end
  end

  assign rdata    = regs[ofs];
  assign page_sel = regs[PAGE_OFS][PAGE_W-1:0];
  assign lin_en   = regs[MODE_OFS][LIN_BIT];
  assign pag_en   = regs[MODE_OFS][PAG_BIT];
  assign win_idx  = regs[MODE_OFS][IDX_W-1:0];

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_q && !rst)
      reset_clear_chk: assert (regs[PAGE_OFS] == '0 && regs[MODE_OFS] == '0)
        else $error("control registers not cleared by reset");
  end

  // R2
  spare_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs != OFS_W'(PAGE_OFS) && ofs != OFS_W'(MODE_OFS))
      |=> ($stable(regs[PAGE_OFS]) && $stable(regs[MODE_OFS])));

  // R3
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ofs == OFS_W'(MODE_OFS)) |=> (regs[MODE_OFS] == $past(wdata)));
endmodule

// File: rtl/nvw_mem_decode.sv
module nvw_mem_decode
  import nvw_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                RAM_AW   = 21,
  parameter int                WIN_AW   = 15,
  parameter logic [ADDR_W-1:0] WIN_LO   = 24'h0A0000,
  parameter logic [ADDR_W-1:0] LIN_BASE = 24'h200000,
  localparam int               PAGE_W   = RAM_AW - WIN_AW,
  localparam int               TAG_W    = ADDR_W - WIN_AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lin_en,
  input  logic              pag_en,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [PAGE_W-1:0] page_sel,
  output logic              hit,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam logic [TAG_W-1:0]  WIN_LO_TAG = WIN_LO[ADDR_W-1:WIN_AW];
  localparam logic [ADDR_W:0]   LIN_SPAN   = (ADDR_W+1)'(1) << RAM_AW;

  map_mode_e          mode;
  logic [TAG_W-1:0]   win_tag;
  logic               pag_hit;
  logic [ADDR_W:0]    lin_off;
  logic               lin_hit;

  assign mode    = pick_mode(lin_en, pag_en);
  assign win_tag = WIN_LO_TAG + TAG_W'(win_idx);
  assign pag_hit = (addr[ADDR_W-1:WIN_AW] == win_tag);
  assign lin_off = {1'b0, addr} - {1'b0, LIN_BASE};
  assign lin_hit = (lin_off < LIN_SPAN);

  always_comb begin
    hit      = 1'b0;
    ram_addr = '0;
    unique case (mode)
      MAP_LINEAR: begin
        hit = lin_hit;
        if (lin_hit) ram_addr = lin_off[RAM_AW-1:0];
      end
      MAP_PAGED: begin
        hit = pag_hit;
        if (pag_hit) ram_addr = {page_sel, addr[WIN_AW-1:0]};
      end
      default: begin
        hit      = 1'b0;
        ram_addr = '0;
      end
    endcase
  end
endmodule

// File: rtl/nvram_window_dec.sv
module nvram_window_dec
  import nvw_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                RAM_AW   = 21,
  parameter int                WIN_AW   = 15,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'h000140,
  parameter logic [ADDR_W-1:0] WIN_LO   = 24'h0A0000,
  parameter logic [ADDR_W-1:0] LIN_BASE = 24'h200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wide,
  input  logic              bus_io,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              io_ack,
  output logic              ram_cs,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_wide
);
  localparam int PAGE_W = RAM_AW - WIN_AW;

  logic              io_hit, io_cyc, mem_cyc, mem_hit;
  logic [REG_W-1:0]  reg_rdata;
  logic [PAGE_W-1:0] page_sel;
  logic              lin_en, pag_en;
  logic [IDX_W-1:0]  win_idx;
  logic [RAM_AW-1:0] dec_addr;

  assign io_hit  = bus_io && (bus_addr[ADDR_W-1:OFS_W] == IO_BASE[ADDR_W-1:OFS_W]);
  assign io_cyc  = io_hit && (bus_rd || bus_wr);
  assign mem_cyc = !bus_io && (bus_rd || bus_wr);

  nvw_regbank #(.PAGE_W(PAGE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (io_hit && bus_wr),
    .ofs      (bus_addr[OFS_W-1:0]),
    .wdata    (bus_wdata),
    .rdata    (reg_rdata),
    .page_sel (page_sel),
    .lin_en   (lin_en),
    .pag_en   (pag_en),
    .win_idx  (win_idx)
  );

  nvw_mem_decode #(
    .ADDR_W   (ADDR_W),
    .RAM_AW   (RAM_AW),
    .WIN_AW   (WIN_AW),
    .WIN_LO   (WIN_LO),
    .LIN_BASE (LIN_BASE)
  ) u_dec (
    .addr     (bus_addr),
    .lin_en   (lin_en),
    .pag_en   (pag_en),
    .win_idx  (win_idx),
    .page_sel (page_sel),
    .hit      (mem_hit),
    .ram_addr (dec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      io_ack    <= 1'b0;
      ram_cs    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_wr    <= 1'b0;
      ram_addr  <= '0;
      ram_wide  <= 1'b0;
    end else begin
      bus_rdata <= (io_hit && bus_rd) ? reg_rdata : '0;
      io_ack    <= io_cyc;
      ram_cs    <= mem_cyc && mem_hit;
      ram_rd    <= mem_cyc && mem_hit && bus_rd;
      ram_wr    <= mem_cyc && mem_hit && bus_wr;
      ram_addr  <= (mem_cyc && mem_hit) ? dec_addr : '0;
      ram_wide  <= cfg_wide;
    end
  end

  // R4
  mem_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!lin_en && !pag_en) |=> (!ram_cs && !ram_rd && !ram_wr && ram_addr == '0));

  // R9
  io_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_io |=> (!ram_cs && !ram_rd && !ram_wr));

  // R9
  mem_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_io |=> !io_ack);
endmodule

// File: tb/sim_nvram_window_dec.sv
module sim_nvram_window_dec;
  localparam logic [23:0] IO_B  = 24'h000140;
  localparam logic [23:0] LIN_B = 24'h200000;

  logic        clk = 1'b0;
  logic        rst, cfg_wide, bus_io, bus_rd, bus_wr;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        io_ack, ram_cs, ram_rd, ram_wr, ram_wide;
  logic [20:0] ram_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] m_page, m_mode;

  always #4 clk = ~clk;

  nvram_window_dec u0 (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .bus_io(bus_io), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .io_ack(io_ack), .ram_cs(ram_cs), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_addr(ram_addr), .ram_wide(ram_wide)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // expected mapping per R4..R8
  function automatic logic [21:0] exp_map(input logic [23:0] a); // {hit, addr}
    logic [24:0] off;
    logic [23:0] wbase;
    if (m_mode[7]) begin
      off = {1'b0, a} - {1'b0, LIN_B};
      if (off < 25'h200000) return {1'b1, off[20:0]};
      return '0;
    end
    if (m_mode[6]) begin
      wbase = 24'h0A0000 + 24'(m_mode[2:0]) * 24'h8000;
      if (a >= wbase && a < wbase + 24'h8000) return {1'b1, m_page[5:0], a[14:0]};
    end
    return '0;
  endfunction

  // one bus cycle with checks of every output
  task automatic cyc_op(input string req, input logic io, input logic rd, input logic wr,
                        input logic [23:0] a, input logic [7:0] d, input logic wide);
    logic        e_ack, e_cs;
    logic [7:0]  e_rd;
    logic [21:0] mp;
    logic        in_bank;
    @(negedge clk);
    bus_io = io; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; cfg_wide = wide;
    in_bank = io && (a[23:3] == IO_B[23:3]);
    e_ack = in_bank && (rd || wr);
    e_rd  = 8'h00;
    if (in_bank && rd) begin
      if (a[2:0] == 3'd4) e_rd = m_page;
      else if (a[2:0] == 3'd5) e_rd = m_mode;
    end
    mp   = (!io && (rd || wr)) ? exp_map(a) : '0;
    e_cs = mp[21];
    if (in_bank && wr) begin
      if (a[2:0] == 3'd4) m_page = d;
      if (a[2:0] == 3'd5) m_mode = d;
    end
    @(posedge clk); #2;
    chk(req, "io_ack R2", io_ack, e_ack);
    chk(req, "bus_rdata R3", bus_rdata, e_rd);
    chk(req, "ram_cs R9", ram_cs, e_cs);
    chk(req, "ram_rd R9", ram_rd, e_cs && rd);
    chk(req, "ram_wr R9", ram_wr, e_cs && wr);
    chk(req, "ram_addr", ram_addr, mp[20:0]);
    chk(req, "ram_wide R10", ram_wide, wide);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    rst = 1; cfg_wide = 0; bus_io = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_page = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    chk("R1", "io_ack", io_ack, 0);
    chk("R1", "ram_cs", ram_cs, 0);
    chk("R1", "ram_addr", ram_addr, 0);
    chk("R1", "bus_rdata", bus_rdata, 0);
    @(negedge clk); rst = 0;

    // R1: registers read zero; R4: memory not decoded
    cyc_op("R1", 1, 1, 0, IO_B + 5, 0, 0);
    cyc_op("R1", 1, 1, 0, IO_B + 4, 0, 0);
    cyc_op("R4", 0, 1, 0, 24'h0D0000, 0, 0);
    cyc_op("R4", 0, 0, 1, 24'h200000, 0, 0);
    // R2: spare location write ignored, reads zero; out-of-bank I/O unclaimed
    cyc_op("R2", 1, 0, 1, IO_B + 2, 8'h5A, 0);
    cyc_op("R2", 1, 1, 0, IO_B + 2, 0, 0);
    cyc_op("R2", 1, 1, 0, IO_B + 5, 0, 0);
    cyc_op("R2", 1, 0, 1, IO_B + 8, 8'hC0, 0);
    cyc_op("R2", 1, 1, 0, IO_B + 5, 0, 0);
    cyc_op("R2", 1, 1, 0, IO_B - 1, 0, 0);
    // R3/R5/R6: paged at 0xD0000, page 5
    cyc_op("R3", 1, 0, 1, IO_B + 5, 8'h46, 0);
    cyc_op("R3", 1, 0, 1, IO_B + 4, 8'h05, 0);
    cyc_op("R3", 1, 1, 0, IO_B + 5, 0, 0);
    cyc_op("R3", 1, 1, 0, IO_B + 4, 0, 0);
    cyc_op("R6", 0, 1, 0, 24'h0D1234, 0, 0);
    cyc_op("R5", 0, 0, 1, 24'h0D7FFF, 0, 1);
    cyc_op("R5", 0, 1, 0, 24'h0D8000, 0, 0);
    cyc_op("R5", 0, 1, 0, 24'h0CFFFF, 0, 0);
    // R9: memory-looking address on I/O cycle, bank address on memory cycle
    cyc_op("R9", 1, 1, 0, 24'h0D0000, 0, 0);
    cyc_op("R9", 0, 1, 0, IO_B + 4, 0, 0);
    // R5 index 0 and 7 edges, page bits above 5 ignored
    cyc_op("R5", 1, 0, 1, IO_B + 5, 8'h40, 0);
    cyc_op("R6", 1, 0, 1, IO_B + 4, 8'hFF, 0);
    cyc_op("R5", 0, 1, 0, 24'h0A0000, 0, 0);
    cyc_op("R5", 0, 1, 0, 24'h09FFFF, 0, 0);
    cyc_op("R5", 1, 0, 1, IO_B + 5, 8'h47, 0);
    cyc_op("R5", 0, 0, 1, 24'h0DFFFF, 0, 1);
    cyc_op("R5", 0, 0, 1, 24'h0E0000, 0, 1);
    // R7: linear range edges
    cyc_op("R7", 1, 0, 1, IO_B + 5, 8'h80, 0);
    cyc_op("R7", 0, 1, 0, 24'h212345, 0, 1);
    cyc_op("R7", 0, 1, 0, 24'h3FFFFF, 0, 0);
    cyc_op("R7", 0, 1, 0, 24'h400000, 0, 0);
    cyc_op("R7", 0, 1, 0, 24'h1FFFFF, 0, 0);
    cyc_op("R7", 0, 0, 1, 24'h200000, 0, 0);
    // R8: both bits set, linear wins
    cyc_op("R8", 1, 0, 1, IO_B + 5, 8'hC6, 0);
    cyc_op("R8", 0, 1, 0, 24'h0D0000, 0, 0);
    cyc_op("R8", 0, 1, 0, 24'h200010, 0, 0);
    // R1: reset in mid-run clears registers
    @(negedge clk); rst = 1; bus_rd = 0; bus_wr = 0;
    @(negedge clk); rst = 0; m_page = 0; m_mode = 0;
    cyc_op("R1", 1, 1, 0, IO_B + 5, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [23:0] a;
      logic [7:0]  d;
      k = $urandom_range(0, 99);
      d = 8'($urandom);
      if (k < 12) begin
        if ($urandom_range(0, 1) == 1) d = {d[7:6], 3'b000, d[2:0]};
        cyc_op("R3", 1, 0, 1, IO_B + 24'($urandom_range(0, 7)), d, 1'($urandom));
      end else if (k < 22) begin
        cyc_op("R2", 1, 1, 0, IO_B + 24'($urandom_range(0, 9)), 0, 1'($urandom));
      end else begin
        case ($urandom_range(0, 2))
          0: a = 24'h0A0000 + 24'($urandom_range(0, 24'h40000 + 24'h8000)) - 24'h4000;
          1: a = LIN_B + 24'($urandom_range(0, 24'h210000)) - 24'h8000;
          default: a = 24'($urandom);
        endcase
        if ($urandom_range(0, 1) == 1)
          cyc_op("R9", 0, 1, 0, a, 0, 1'($urandom));
        else
          cyc_op("R9", 0, 0, 1, a, 0, 1'($urandom));
      end
    end
    finish_run();
  end
endmodule